// File: doc/BRIEF.md
# Next Program Counter Unit

This unit holds the program counter of a single-cycle processor and chooses its next value on every rising clock edge. The current PC is driven out to address instruction memory. The word that memory returns comes back in combinationally, together with the decoded control for that word. From these inputs the unit picks one of three successors: the incremented address, a PC-relative branch target, or an absolute jump target. The jump target keeps the region bits of the incremented address.

The PC register has no enable, so the unit advances on every cycle. It has no valid/ready handshake and cannot be stalled; back-pressure does not exist at this boundary. The instruction word, the branch and jump decodes and the ALU equality flag are plain level inputs. They are sampled at the clock edge that ends the cycle in which they were presented. The branch offset is read from bits 15:0 of the instruction word, and the jump index from bits 25:0.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with `RESET_PC` (default 0x00000000), whatever the other inputs are.
- R2: With `jump_op` low and no taken branch, the PC becomes PC + 4 on every edge; there is no enable that holds it.
- R3: The increment wraps modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R4: When `branch_op` and `alu_zero` are both high and `jump_op` is low, the PC becomes (PC + 4) + (sign-extended `instr_word[15:0]` << 2).
- R5: When `branch_op` is high and `alu_zero` is low, the branch is not taken and the PC becomes PC + 4.
- R6: A branch offset with bit 15 set is negative: its upper bits are filled with ones before the shift, so the target lies below PC + 4.
- R7: When `jump_op` is high, the PC becomes {(PC + 4)[31:28], `instr_word[25:0]`, 2'b00}.
- R8: `jump_op` wins over a taken branch when both are present.
- R9: The four region bits of a jump come from PC + 4, not from the current PC. This differs when the PC is the last word of a 256 MiB region.
- R10: `alu_zero` high with `branch_op` low has no effect: the PC becomes PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Fetched instruction: offset in bits 15:0, jump index in bits 25:0 |
| branch_op | input | 1 | Decoded conditional branch on equality |
| alu_zero | input | 1 | ALU equality flag (operands equal) |
| jump_op | input | 1 | Decoded absolute jump |
| pc | output | 32 | Current program counter, instruction memory address |

## Verification
The bench goes after the offset sign boundary (0x7FFF against 0x8000). A design that zero-extended the offset would send backward branches about 256 KiB forward. It drives a jump from the last word of a region: a design that took the region bits from the current PC would land one region low. It applies a branch and a jump together, and the equality flag without a branch decode, which catch a wrong priority or a missing AND of the two branch conditions. It also steps from 0xFFFFFFFC, so an increment that saturated instead of wrapping would be seen. Thousands of pseudo-random instruction words and control mixes then compare each successor with arithmetic done in the bench.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_BR   = 2'd1,
    SRC_JMP  = 2'd2
  } pc_src_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] cur_pc,
  output logic [ADDR_W-1:0] pc_inc
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  assign pc_inc = cur_pc + STEP_V;
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign target  = base + (off_ext << SHIFT);
endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 26,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [TGT_W-1:0]  index,
  output logic [ADDR_W-1:0] target
);
  localparam int REGION_W = ADDR_W - TGT_W - SHIFT;
  generate
    if (REGION_W > 0) begin : g_region
      assign target = {base[ADDR_W-1 -: REGION_W], index, {SHIFT{1'b0}}};
    end else begin : g_noregion
      logic [TGT_W+SHIFT-1:0] full;
      assign full   = {index, {SHIFT{1'b0}}};
      assign target = full[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              branch_op,
  input  logic              alu_zero,
  input  logic              jump_op,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] jmp_pc,
  output pc_src_e           src,
  output logic [ADDR_W-1:0] next_pc
);
  always_comb begin
    if (jump_op)                     src = SRC_JMP;
    else if (branch_op && alu_zero)  src = SRC_BR;
    else                             src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JMP: next_pc = jmp_pc;
      SRC_BR:  next_pc = br_pc;
      default: next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                INSTR_W  = 32,
  parameter int                OFF_W    = 16,
  parameter int                TGT_W    = 26,
  parameter int                STEP     = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               branch_op,
  input  logic               alu_zero,
  input  logic               jump_op,
  output logic [ADDR_W-1:0]  pc
);
  localparam int SHIFT = $clog2(STEP);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] jmp_pc;
  logic [ADDR_W-1:0] next_pc;
  pc_src_e           src;

  npc_incr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_incr (
    .cur_pc (pc_q),
    .pc_inc (pc_inc)
  );

  npc_branch_tgt #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_br (
    .base   (pc_inc),
    .offset (instr_word[OFF_W-1:0]),
    .target (br_pc)
  );

  npc_jump_tgt #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .SHIFT(SHIFT)) u_jmp (
    .base   (pc_inc),
    .index  (instr_word[TGT_W-1:0]),
    .target (jmp_pc)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .branch_op (branch_op),
    .alu_zero  (alu_zero),
    .jump_op   (jump_op),
    .seq_pc    (pc_inc),
    .br_pc     (br_pc),
    .jmp_pc    (jmp_pc),
    .src       (src),
    .next_pc   (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= next_pc;
  end

  assign pc = pc_q;

  // Independent reference quantities for the checks below
  localparam logic [ADDR_W-1:0] STEP_C = ADDR_W'(STEP);
  logic [ADDR_W-1:0] chk_delta;
  assign chk_delta = ADDR_W'($signed(instr_word[OFF_W-1:0])) << SHIFT;

  p_reset_r1: assert property (@(posedge clk) rst |=> pc == RESET_PC);

  // R2, R3, R5, R10: no redirect means a plain step (modular)
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!jump_op && !(branch_op && alu_zero)) |=> pc == $past(pc) + STEP_C);

  // R4, R6: taken branch moves by step plus the scaled signed offset
  p_branch_move_r4: assert property (@(posedge clk) disable iff (rst)
    (branch_op && alu_zero && !jump_op) |=> pc == $past(pc) + STEP_C + $past(chk_delta));

  // R7: a jump always lands on a word boundary with the index in place
  p_jump_index_r7: assert property (@(posedge clk) disable iff (rst)
    jump_op |=> pc[TGT_W+SHIFT-1:0] == {$past(instr_word[TGT_W-1:0]), {SHIFT{1'b0}}});

  // R8, R9: jump wins and its region comes from the incremented address
  p_jump_region_r9: assert property (@(posedge clk) disable iff (rst)
    jump_op |=> pc[ADDR_W-1:TGT_W+SHIFT] == $past(pc_inc[ADDR_W-1:TGT_W+SHIFT]));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_word = '0;
  logic        branch_op = 1'b0;
  logic        alu_zero = 1'b0;
  logic        jump_op = 1'b0;
  logic [31:0] pc;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_pc = 32'h0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst(rst), .instr_word(instr_word),
    .branch_op(branch_op), .alu_zero(alu_zero), .jump_op(jump_op), .pc(pc)
  );

  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] iw,
                                             input logic b, input logic z, input logic j);
    logic [31:0] inc;
    inc = cur + 32'd4;
    if (j)           return {inc[31:28], iw[25:0], 2'b00};
    else if (b && z) return inc + {{14{iw[15]}}, iw[15:0], 2'b00};
    else             return inc;
  endfunction

  function automatic string classify(input logic [31:0] cur, input logic [31:0] iw,
                                     input logic b, input logic z, input logic j);
    if (j && b && z) return "R8";
    if (j)           return "R7";
    if (b && z)      return iw[15] ? "R6" : "R4";
    if (b)           return "R5";
    if (z)           return "R10";
    if (cur == 32'hFFFF_FFFC) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_errors++;
      $display("FAIL %s: pc=%h expected=%h", tag, got, want);
    end
  endtask

  // Called just after a falling edge; result checked at the next falling edge
  task automatic step(input logic [31:0] iw, input logic b, input logic z,
                      input logic j, input string tag);
    logic [31:0] nxt;
    instr_word = iw; branch_op = b; alu_zero = z; jump_op = j;
    nxt = model_next(exp_pc, iw, b, z, j);
    @(negedge clk);
    check(tag, pc, nxt);
    exp_pc = nxt;
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; jump_op = 1'b1; branch_op = 1'b1; alu_zero = 1'b1;
    instr_word = 32'hFFFF_FFFF;
    @(negedge clk);
    check(tag, pc, 32'h0);
    rst = 1'b0;
    exp_pc = 32'h0;
  endtask

  initial begin
    logic [31:0] s;
    @(negedge clk);
    @(negedge clk);
    do_reset("R1");

    // R2: plain stepping, no enable holds it
    for (int i = 0; i < 4; i++) step(32'h1234_5678, 1'b0, 1'b0, 1'b0, "R2");
    // R10: equality flag without branch decode is ignored
    step(32'h0000_0100, 1'b0, 1'b1, 1'b0, "R10");
    // R5: branch decoded but operands differ
    step(32'h0000_0100, 1'b1, 1'b0, 1'b0, "R5");
    // R4: largest positive offset, then zero offset
    step(32'h0000_7FFF, 1'b1, 1'b1, 1'b0, "R4");
    step(32'h0000_0000, 1'b1, 1'b1, 1'b0, "R4");
    // R6: most negative offset, then -1
    step(32'h0000_8000, 1'b1, 1'b1, 1'b0, "R6");
    step(32'h0000_FFFF, 1'b1, 1'b1, 1'b0, "R6");
    // R8: jump with a taken branch present
    step(32'h0000_0040, 1'b1, 1'b1, 1'b1, "R8");
    // R7: jump extremes
    step(32'h03FF_FFFF, 1'b0, 1'b0, 1'b1, "R7");
    check("R7", pc, 32'h0FFF_FFFC);
    // R9: from last word of region 0, jump lands in region 1
    step(32'h0000_0005, 1'b0, 1'b0, 1'b1, "R9");
    check("R9", pc, 32'h1000_0014);

    // R3: reach the top of the address space and wrap
    do_reset("R1");
    step(32'h0000_FFFE, 1'b1, 1'b1, 1'b0, "R6");
    check("R6", pc, 32'hFFFF_FFFC);
    step(32'h0000_0000, 1'b0, 1'b0, 1'b0, "R3");
    check("R3", pc, 32'h0000_0000);
    // R9: jump from 0xFFFFFFFC takes region 0 from the wrapped increment
    step(32'h0000_FFFE, 1'b1, 1'b1, 1'b0, "R6");
    step(32'h0000_0003, 1'b0, 1'b0, 1'b1, "R9");
    check("R9", pc, 32'h0000_000C);

    // Sweep over pseudo-random words and control mixes
    s = 32'hACE1_2468;
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] iw;
      logic b, z, j;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      iw = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b = s[0]; z = s[1]; j = (s[4:2] == 3'd0);
      step(iw, b, z, j, classify(exp_pc, iw, b, z, j));
    end

    do_reset("R1");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule